// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block sits between a host CPU and a secure coprocessor. On the host side it is a 32-bit register window. The host first loads up to sixteen argument words. It then writes a command word, and that write takes a snapshot of all the arguments together with the 16-bit command value. The snapshot goes into a short first-in first-out queue. On the coprocessor side the head of the queue is shown as a valid flag, a command and the flattened arguments.

The coprocessor finishes the head command with a single strobe. That strobe carries a return word and sixteen status words. The block latches these for the host and removes the head entry from the queue.

Three events are kept in a sticky cause register, which the host clears by writing ones: command done, a command dropped because the queue was full, and the queue becoming full. Each cause bit has a mask bit. The host interrupt is a level signal that is high while any unmasked cause bit is set.

Top module: `cmdmb_top`

## Requirements
- R1: After reset the queue count reads 0, the cause register reads 0, the mask register reads 0x0006_0001 (all three sources masked), the return word reads 0 and `host_irq` is low.
- R2: Argument word i is written and read back at byte offset 4·i, for i from 0 to 15. Writing offset 0x40 queues the current argument words together with write-data bits [15:0] as the command. While the queue holds entries, `cp_cmd_valid` is high, and `cp_cmd` and `cp_cmd_args` show the oldest entry, with argument i at bits [32·i+31:32·i].
- R3: Entries leave the queue in the order they were written. Offset 0xC4 reads the entry count in bits [2:0] and the `cp_ready` input in bit 8, with all other bits 0.
- R4: A command write while 4 entries are queued is dropped, even if a completion happens in the same cycle. The count and the head entry are left unchanged, and cause bit 17 is set.
- R5: Cause bit 18 is set in the cycle the queue count becomes 4.
- R6: A `cp_done` pulse while the queue is not empty does three things. It latches `cp_ret`, readable at 0x80, and status word i of `cp_status`, readable at 0x84+4·i. It sets cause bit 0. It removes the head entry.
- R7: A `cp_done` pulse with an empty queue changes nothing: not the result words, not the cause register, not the count.
- R8: Writing 0xC8 clears each cause bit whose write-data bit is 1. An event in the same cycle as a clear leaves its bit set. Cause bits other than 0, 17 and 18 always read 0.
- R9: Offset 0xCC holds the mask bits 0, 17 and 18; a 1 masks the source and all other bits read 0. `host_irq` is high exactly when some cause bit is set and its mask bit is 0.
- R10: Reads return 0 at the command offset, at undefined offsets, at unaligned addresses and whenever `host_rd_en` is low. Writes to undefined offsets and to the result and status offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read enable, data is returned in the same cycle |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_irq | output | 1 | Level interrupt to the host |
| cp_ready | input | 1 | Coprocessor ready flag, reflected in the queue status register |
| cp_cmd_valid | output | 1 | Queue holds at least one command |
| cp_cmd | output | 16 | Command value of the head entry |
| cp_cmd_args | output | 512 | Sixteen argument words of the head entry |
| cp_done | input | 1 | Completion strobe: posts the result and removes the head entry |
| cp_ret | input | 32 | Return word posted with `cp_done` |
| cp_status | input | 512 | Sixteen status words posted with `cp_done` |

## Verification
A wrong queue pointer or count shows up one cycle after the faulty push or pop. It appears either as a wrong head on the coprocessor port or as a wrong count in the status register, so it is checked after every random operation against a queue model kept in the bench. A cause or mask bit that sets, clears or resets wrongly shows in the cause and mask reads and on `host_irq` one cycle after the event. Result latching and the empty-completion case are visible directly in the return and status reads. Directed cases cover a full queue with a dropped command, a clear that meets an event in the same cycle, and reads of offsets that hold no register.

// File: rtl/cmdmb_pkg.sv
// Package: shared constants of the command mailbox.
// Assumes byte offsets fixed by the host software contract; 4-byte aligned words.
package cmdmb_pkg;
    localparam int unsigned CMDMB_WORD_W = 32;
    localparam int unsigned CMDMB_NARGS  = 16;
    localparam int unsigned CMDMB_DEPTH  = 4;
    localparam int unsigned CMDMB_CMD_W  = 16;
    localparam int unsigned CMDMB_ADDR_W = 8;

    localparam logic [7:0] OFS_CMD   = 8'h40;
    localparam logic [7:0] OFS_RET   = 8'h80;
    localparam logic [7:0] OFS_STAT0 = 8'h84;
    localparam logic [7:0] OFS_QSTAT = 8'hC4;
    localparam logic [7:0] OFS_CAUSE = 8'hC8;
    localparam logic [7:0] OFS_MASK  = 8'hCC;

    localparam int unsigned BIT_DONE = 0;
    localparam int unsigned BIT_DROP = 17;
    localparam int unsigned BIT_FULL = 18;
    localparam int unsigned BIT_RDY  = 8;
endpackage

// File: rtl/cmdmb_cmd_queue.sv
// Module: message queue of fixed-width entries, first in first out.
// Assumes a push while full is discarded (push is checked before any pop of the
// same cycle) and a pop while empty is ignored. Storage is not reset.
module cmdmb_cmd_queue #(
    parameter  int unsigned ENTRY_W = 528,
    parameter  int unsigned DEPTH   = 4,
    localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head_data,
    output logic [CNT_W-1:0]   count,
    output logic               full,
    output logic               empty,
    output logic               fill_event
);
    logic [ENTRY_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic               push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (count == CNT_W'(DEPTH));
    assign empty      = (count == '0);
    assign push_ok    = push && !full;
    assign pop_ok     = pop && !empty;
    assign fill_event = push_ok && !pop_ok && (count == CNT_W'(DEPTH - 1));
    assign head_data  = slot_q[rd_ptr];

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) slot_q[wr_ptr] <= push_data;
    end

    // Advance the pointers and keep the entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: a push into a full queue without a pop leaves it full
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CNT_W'(DEPTH)));

    // R7: a pop of an empty queue without a push leaves it empty
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

    // R3: the count never exceeds the depth
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/cmdmb_result_buf.sv
// Module: holds the return word and status words of the last completion.
// Assumes load is only raised for a completion that has a queued command.
module cmdmb_result_buf #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NARGS  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [WORD_W-1:0]       ret_in,
    input  logic [NARGS*WORD_W-1:0] stat_in,
    output logic [WORD_W-1:0]       ret_q,
    output logic [NARGS*WORD_W-1:0] stat_q
);
    // Capture a completion; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q  <= '0;
            stat_q <= '0;
        end else if (load) begin
            ret_q  <= ret_in;
            stat_q <= stat_in;
        end
    end

    // R6: a load makes the posted words visible in the next cycle
    p_load_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ret_q == $past(ret_in)) && (stat_q == $past(stat_in)));

    // R7: without a load the result words hold
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ret_q) && $stable(stat_q));
endmodule

// File: rtl/cmdmb_irq_ctrl.sv
// Module: sticky cause bits (write 1 to clear), mask bits and level interrupt.
// Assumes IMPL_MASK names the implemented bits; the rest stay zero. An event
// wins over a clear in the same cycle. Reset masks every implemented source.
module cmdmb_irq_ctrl #(
    parameter int unsigned       WORD_W    = 32,
    parameter logic [WORD_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [WORD_W-1:0] clr_data,
    input  logic              mask_wr,
    input  logic [WORD_W-1:0] mask_data,
    output logic [WORD_W-1:0] cause_q,
    output logic [WORD_W-1:0] mask_q,
    output logic              irq
);
    logic [WORD_W-1:0] clr_vec;

    assign clr_vec = clr_wr ? clr_data : '0;
    assign irq     = |(cause_q & ~mask_q);

    // Update the cause bits: keep, clear on write-1, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= ((cause_q & ~clr_vec) | set_vec) & IMPL_MASK;
    end

    // Load the mask bits from the host; all sources masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= IMPL_MASK;
        else if (mask_wr) mask_q <= mask_data & IMPL_MASK;
    end

    // R8: an event on an implemented bit is visible next cycle despite a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & IMPL_MASK) != '0) |=> ((cause_q & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

    // R8: a cleared bit with no event is zero next cycle
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((cause_q & $past(clr_data & ~set_vec)) == '0));

    // R9: unimplemented bits never read as set
    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q | mask_q) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/cmdmb_top.sv
// Module: host register window, argument staging, command queue, completion
// buffer and interrupt causes of the command mailbox.
// Assumes one host access per cycle, read data valid in the same cycle as
// host_rd_en, and cp_done meaning "head finished, result posted".
module cmdmb_top
    import cmdmb_pkg::*;
#(
    parameter  int unsigned WORD_W  = CMDMB_WORD_W,
    parameter  int unsigned NARGS   = CMDMB_NARGS,
    parameter  int unsigned DEPTH   = CMDMB_DEPTH,
    parameter  int unsigned CMD_W   = CMDMB_CMD_W,
    parameter  int unsigned ADDR_W  = CMDMB_ADDR_W,
    localparam int unsigned ENTRY_W = CMD_W + NARGS * WORD_W,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W   = (NARGS > 1) ? $clog2(NARGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic                    host_wr_en,
    input  logic                    host_rd_en,
    input  logic [WORD_W-1:0]       host_wdata,
    output logic [WORD_W-1:0]       host_rdata,
    output logic                    host_irq,
    input  logic                    cp_ready,
    output logic                    cp_cmd_valid,
    output logic [CMD_W-1:0]        cp_cmd,
    output logic [NARGS*WORD_W-1:0] cp_cmd_args,
    input  logic                    cp_done,
    input  logic [WORD_W-1:0]       cp_ret,
    input  logic [NARGS*WORD_W-1:0] cp_status
);
    localparam logic [WORD_W-1:0] IMPL = WORD_W'((1 << BIT_DONE) | (1 << BIT_DROP) | (1 << BIT_FULL));
    localparam logic [ADDR_W:0]   ARG_END  = (ADDR_W+1)'(4 * NARGS);
    localparam logic [ADDR_W:0]   STAT_END = (ADDR_W+1)'(OFS_STAT0) + (ADDR_W+1)'(4 * NARGS);

    logic [WORD_W-1:0]       arg_q [NARGS];
    logic [NARGS*WORD_W-1:0] args_flat;
    logic [WORD_W-1:0]       stat_word [NARGS];
    logic [ENTRY_W-1:0]      head;
    logic [CNT_W-1:0]        q_count;
    logic                    q_full, q_empty, q_fill;
    logic [WORD_W-1:0]       ret_q;
    logic [NARGS*WORD_W-1:0] stat_q;
    logic [WORD_W-1:0]       cause_q, mask_q, set_vec, qstat_word;
    logic                    aligned, arg_hit, stat_hit, cmd_wr, done_ok;
    logic [IDX_W-1:0]        arg_idx, stat_idx;

    // Decode the aligned host address into register regions.
    assign aligned  = (host_addr[1:0] == 2'b00);
    assign arg_hit  = aligned && ({1'b0, host_addr} < ARG_END);
    assign stat_hit = aligned && ({1'b0, host_addr} >= (ADDR_W+1)'(OFS_STAT0))
                              && ({1'b0, host_addr} < STAT_END);
    assign arg_idx  = IDX_W'(host_addr >> 2);
    assign stat_idx = IDX_W'((host_addr - ADDR_W'(OFS_STAT0)) >> 2);
    assign cmd_wr   = host_wr_en && (host_addr == ADDR_W'(OFS_CMD));
    assign done_ok  = cp_done && !q_empty;

    // Hold the argument staging registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NARGS); i++) arg_q[i] <= '0;
        end else if (host_wr_en && arg_hit) begin
            arg_q[arg_idx] <= host_wdata;
        end
    end

    // Flatten the staged arguments and unflatten the latched status words.
    for (genvar g = 0; g < int'(NARGS); g++) begin : g_words
        assign args_flat[g*WORD_W +: WORD_W] = arg_q[g];
        assign stat_word[g]                  = stat_q[g*WORD_W +: WORD_W];
    end

    cmdmb_cmd_queue #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cmd_wr),
        .push_data ({host_wdata[CMD_W-1:0], args_flat}),
        .pop       (cp_done),
        .head_data (head),
        .count     (q_count),
        .full      (q_full),
        .empty     (q_empty),
        .fill_event(q_fill)
    );

    assign cp_cmd_valid = !q_empty;
    assign cp_cmd       = head[ENTRY_W-1 -: CMD_W];
    assign cp_cmd_args  = head[NARGS*WORD_W-1:0];

    cmdmb_result_buf #(.WORD_W(WORD_W), .NARGS(NARGS)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (done_ok),
        .ret_in (cp_ret),
        .stat_in(cp_status),
        .ret_q  (ret_q),
        .stat_q (stat_q)
    );

    // Collect the event sources into the cause bit positions.
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_DONE] = done_ok;
        set_vec[BIT_DROP] = cmd_wr && q_full;
        set_vec[BIT_FULL] = q_fill;
    end

    cmdmb_irq_ctrl #(.WORD_W(WORD_W), .IMPL_MASK(IMPL)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (host_wr_en && (host_addr == ADDR_W'(OFS_CAUSE))),
        .clr_data (host_wdata),
        .mask_wr  (host_wr_en && (host_addr == ADDR_W'(OFS_MASK))),
        .mask_data(host_wdata),
        .cause_q  (cause_q),
        .mask_q   (mask_q),
        .irq      (host_irq)
    );

    // Build the queue status word: count and coprocessor ready flag.
    always_comb begin
        qstat_word                = '0;
        qstat_word[CNT_W-1:0]     = q_count;
        qstat_word[BIT_RDY]       = cp_ready;
    end

    // Select the read data; everything undefined reads zero.
    always_comb begin
        host_rdata = '0;
        if (host_rd_en) begin
            if (arg_hit)                                 host_rdata = arg_q[arg_idx];
            else if (stat_hit)                           host_rdata = stat_word[stat_idx];
            else if (host_addr == ADDR_W'(OFS_RET))      host_rdata = ret_q;
            else if (host_addr == ADDR_W'(OFS_QSTAT))    host_rdata = qstat_word;
            else if (host_addr == ADDR_W'(OFS_CAUSE))    host_rdata = cause_q;
            else if (host_addr == ADDR_W'(OFS_MASK))     host_rdata = mask_q;
        end
    end

    // R4: a command written into a full queue raises the drop cause
    p_drop_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && q_full) |=> cause_q[BIT_DROP]);

    // R7: a completion with an empty queue raises no done cause by itself
    p_empty_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_done && q_empty && !cause_q[BIT_DONE]) |=> !cause_q[BIT_DONE]);

    // R9: the interrupt is only high with an unmasked cause pending
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ((cause_q & ~mask_q) != '0));

    // R10: no read data without a read enable
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |-> (host_rdata == '0));
endmodule

// File: tb/sim_cmdmb_top.sv
// Bench: directed corner cases plus seeded random operations, checked against
// a queue, cause, mask and result model kept in the bench.
module sim_cmdmb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 16;
    localparam int W  = 32;
    localparam logic [31:0] IMPL = 32'h0006_0001;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n = 1'b0;
    logic [7:0]    host_addr = '0;
    logic          host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [31:0]   host_wdata = '0, host_rdata;
    logic          host_irq, cp_ready = 1'b0, cp_cmd_valid, cp_done = 1'b0;
    logic [15:0]   cp_cmd;
    logic [NA*W-1:0] cp_cmd_args, cp_status = '0;
    logic [31:0]   cp_ret = '0;

    cmdmb_top u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
        .host_rd_en(host_rd_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .cp_ready(cp_ready), .cp_cmd_valid(cp_cmd_valid),
        .cp_cmd(cp_cmd), .cp_cmd_args(cp_cmd_args), .cp_done(cp_done),
        .cp_ret(cp_ret), .cp_status(cp_status)
    );

    int n_chk = 0, n_fail = 0;

    // Model state
    logic [15:0]     m_cmd [4];
    logic [NA*W-1:0] m_arg [4];
    int              m_cnt = 0;
    logic [31:0]     m_areg [NA];
    logic [31:0]     m_cause = '0, m_mask = IMPL, m_ret = '0;
    logic [NA*W-1:0] m_stat = '0;

    function automatic logic [NA*W-1:0] pack_args();
        logic [NA*W-1:0] v;
        for (int i = 0; i < NA; i++) v[i*W +: W] = m_areg[i];
        return v;
    endfunction

    function automatic logic exp_irq();
        return |(m_cause & ~m_mask);
    endfunction

    function automatic logic [31:0] exp_qstat();
        return 32'(m_cnt) | (32'(cp_ready) << 8);
    endfunction

    task automatic chk(input string tag, input logic [NA*W-1:0] got, input logic [NA*W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd_en = 1'b1;
        #1 d = host_rdata;
        host_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_arg(input int i, input logic [31:0] d);
        wr(8'(i*4), d);
        m_areg[i] = d;
    endtask

    task automatic host_cmd(input logic [31:0] c);
        wr(8'h40, c);
        if (m_cnt == 4) m_cause |= 32'h0002_0000;
        else begin
            m_cmd[m_cnt] = c[15:0];
            m_arg[m_cnt] = pack_args();
            m_cnt++;
            if (m_cnt == 4) m_cause |= 32'h0004_0000;
        end
    endtask

    task automatic model_pop();
        m_ret = cp_ret;
        m_stat = cp_status;
        m_cause |= 32'h1;
        for (int k = 0; k < 3; k++) begin
            m_cmd[k] = m_cmd[k+1];
            m_arg[k] = m_arg[k+1];
        end
        m_cnt--;
    endtask

    task automatic cp_complete();
        @(negedge clk);
        cp_done = 1'b1;
        cp_ret = $urandom;
        for (int i = 0; i < NA; i++) cp_status[i*W +: W] = $urandom;
        @(negedge clk);
        cp_done = 1'b0;
        if (m_cnt > 0) model_pop();
    endtask

    task automatic host_clr(input logic [31:0] d);
        wr(8'hC8, d);
        m_cause &= ~d;
    endtask

    task automatic host_mask(input logic [31:0] d);
        wr(8'hCC, d);
        m_mask = d & IMPL;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] d;
        rd(8'hC4, d);  chk({"R3 queue status ", ctx}, d, exp_qstat());
        rd(8'hC8, d);  chk({"R8 cause ", ctx}, d, m_cause);
        rd(8'hCC, d);  chk({"R9 mask ", ctx}, d, m_mask);
        chk({"R9 irq ", ctx}, host_irq, exp_irq());
        rd(8'h80, d);  chk({"R6 return word ", ctx}, d, m_ret);
        chk({"R2 cmd valid ", ctx}, cp_cmd_valid, m_cnt > 0);
        if (m_cnt > 0) begin
            chk({"R3 head cmd ", ctx}, cp_cmd, m_cmd[0]);
            chk({"R3 head args ", ctx}, cp_cmd_args, m_arg[0]);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NA; i++) m_areg[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'hC4, d); chk("R1 count after reset", d, 32'h0);
        rd(8'hC8, d); chk("R1 cause after reset", d, 32'h0);
        rd(8'hCC, d); chk("R1 mask after reset", d, 32'h0006_0001);
        rd(8'h80, d); chk("R1 return after reset", d, 32'h0);
        chk("R1 irq after reset", host_irq, 1'b0);

        // R2: argument readback and command submission
        for (int i = 0; i < NA; i++) host_arg(i, $urandom);
        for (int i = 0; i < NA; i++) begin
            rd(8'(i*4), d); chk("R2 argument readback", d, m_areg[i]);
        end
        host_cmd(32'hABCD_1234);
        chk("R2 head cmd low half", cp_cmd, 16'h1234);
        chk("R2 head args snapshot", cp_cmd_args, pack_args());
        cp_ready = 1'b1;
        rd(8'hC4, d); chk("R3 ready bit and count", d, 32'h0000_0101);
        check_all("after one command");

        // R5 / R4: fill and overflow with all sources masked
        for (int n = 0; n < 3; n++) begin
            host_arg(n, $urandom);
            host_cmd($urandom);
        end
        check_all("R5 queue full");
        chk("R9 masked full gives no irq", host_irq, 1'b0);
        host_arg(0, 32'hDEAD_BEEF);
        host_cmd(32'h0000_7777);
        check_all("R4 dropped command");
        host_mask(32'h0);
        chk("R9 unmasked irq", host_irq, 1'b1);

        // R6: completions drain in order
        for (int n = 0; n < 4; n++) begin
            cp_complete();
            check_all("R6 completion");
            for (int i = 0; i < NA; i++) begin
                rd(8'(8'h84 + i*4), d); chk("R6 status word", d, m_stat[i*W +: W]);
            end
        end

        // R7: completion with empty queue is ignored
        host_clr(32'hFFFF_FFFF);
        chk("R9 irq low after clear", host_irq, 1'b0);
        cp_complete();
        check_all("R7 empty completion");
        rd(8'h84, d); chk("R7 status unchanged", d, m_stat[31:0]);

        // R8: event in the same cycle as a clear keeps the bit
        host_cmd(32'h55);
        host_clr(32'h0004_0000);
        @(negedge clk);
        cp_done = 1'b1; cp_ret = 32'h1357_9BDF;
        host_addr = 8'hC8; host_wdata = 32'h1; host_wr_en = 1'b1;
        @(negedge clk);
        cp_done = 1'b0; host_wr_en = 1'b0;
        model_pop();
        check_all("R8 set beats clear");

        // R10: undefined and unaligned reads, ignored writes
        rd(8'h40, d); chk("R10 command reads zero", d, 32'h0);
        rd(8'h44, d); chk("R10 gap reads zero", d, 32'h0);
        rd(8'h02, d); chk("R10 unaligned reads zero", d, 32'h0);
        rd(8'hD0, d); chk("R10 past end reads zero", d, 32'h0);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'hC4, 32'hFFFF_FFFF);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h88, d); chk("R10 status write ignored", d, m_stat[63:32]);
        check_all("R10 ignored writes");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: host_arg(int'($urandom_range(0, NA-1)), $urandom);
                1: host_cmd($urandom);
                2: cp_complete();
                3: host_clr($urandom);
                4: host_mask($urandom);
                default: cp_ready = ~cp_ready;
            endcase
            check_all("random");
        end

        finish_run();
    end
endmodule